// File: doc/BRIEF.md
# Accelerometer Offset Calibration Engine

This block finds and loads the offset trims of a three-axis accelerometer that lies flat with its Z axis pointing up. It drives the same register-write port that a host serial controller would use, and it reads the controller's stream of decoded samples.

When started, it does the following in turn:
- programs the sensor for full-resolution measurement with a data-ready interrupt;
- zeroes the three offset registers;
- waits for the output to settle;
- sums a fixed number of samples on each axis.

Each per-axis sum is then turned into an 8-bit two's-complement correction. One offset step is worth four data LSBs, so the correction is the negated mean divided by four. X and Y are referenced to 0 g. Z is referenced to +1 g, which is 256 data LSBs.

The engine writes the three corrections back to the offset registers, X first and Z last. It keeps them on its outputs, together with a per-axis out-of-range flag, and pulses `done_o`. The division is carried out sequentially, one axis at a time, so the only datapath is a small remainder register and one comparator.

Top module: `accel_offset_cal`

## Requirements
- R1: A `start_i` taken while idle issues six writes, one per handshake, as {address, data}: {0x31,0x0B}, {0x2D,0x08}, {0x2E,0x80}, then {0x1E,0x00}, {0x1F,0x00}, {0x20,0x00}.
- R2: A write takes place on a clock edge where `wr_valid_o` and `wr_ready_i` are both high. While `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold steady.
- R3: For `SETTLE_CYC` cycles after the sixth write, samples are ignored.
- R4: Exactly `N_SMP` samples with `smp_valid_i` high are summed per axis. Samples that arrive after that, up to the next start, have no effect.
- R5: The correction is round((ref·N_SMP − sum) / (4·N_SMP)), with halves rounded away from zero. ref is 0 for X and Y, and 256 for Z.
- R6: A correction above +127 gives 127 (0x7F). One below −128 gives −128 (0x80). In both cases the axis's `oor_o` bit is set: bit 0 for X, bit 1 for Y, bit 2 for Z. A correction of exactly −128 or +127 is not flagged.
- R7: After the computation, three writes follow in this order: {0x1E, X trim}, {0x1F, Y trim}, {0x20, Z trim}.
- R8: `done_o` is high for exactly one cycle, the cycle after the Z trim write. At that point the trim outputs and `oor_o` carry the results, and they hold them until the next start. `busy_o` falls after `done_o`.
- R9: A `start_i` that arrives while busy is ignored. The run completes with exactly nine writes and one `done_o`.
- R10: After reset, `busy_o`, `done_o`, `wr_valid_o`, the three trims and `oor_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration run |
| smp_valid_i | input | 1 | Sample triple valid |
| smp_x_i | input | SMP_W | X sample, two's complement |
| smp_y_i | input | SMP_W | Y sample, two's complement |
| smp_z_i | input | SMP_W | Z sample, two's complement |
| wr_valid_o | output | 1 | Register write request |
| wr_ready_i | input | 1 | Controller accepts the write |
| wr_addr_o | output | 8 | Register address |
| wr_data_o | output | 8 | Register data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trim_x_o | output | 8 | X correction |
| trim_y_o | output | 8 | Y correction |
| trim_z_o | output | 8 | Z correction |
| oor_o | output | 3 | Per-axis saturation flags |

## Verification
The bench targets three sets of corner cases.

- **Rounding and saturation edges.** It drives means that land exactly on half a trim step, and means whose corrections come out at exactly +127, +128, −128 and −129. A truncating divider would produce results one step too small. A saturator with an off-by-one limit would clip at −128 by mistake, or let 128 wrap to −128.
- **Samples outside the summing window.** Large junk samples are presented during settling and again after the last counted sample. A design that opened the summing window early, or kept summing once the window had closed, would return trims far from the expected ones.
- **Handshake and extra starts.** Random back-pressure on the write port and a second start pulse during the run show up as write sequences that are duplicated, reordered or over-long, and as repeated done pulses.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NAX = 3;
  localparam int TW  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_SETTLE, ST_ACC, ST_DGO, ST_DWAIT, ST_TRIM, ST_DONE
  } cal_st_e;

  // register map used by the write sequence
  localparam logic [7:0] A_FMT   = 8'h31;
  localparam logic [7:0] A_PWR   = 8'h2D;
  localparam logic [7:0] A_IEN   = 8'h2E;
  localparam logic [7:0] A_OFS_X = 8'h1E;
  localparam logic [7:0] A_OFS_Y = 8'h1F;
  localparam logic [7:0] A_OFS_Z = 8'h20;
  localparam logic [7:0] V_FMT   = 8'h0B;
  localparam logic [7:0] V_PWR   = 8'h08;
  localparam logic [7:0] V_IEN   = 8'h80;

  localparam logic [3:0] IDX_LAST_CLR   = 4'd5;
  localparam logic [3:0] IDX_FIRST_TRIM = 4'd6;
  localparam logic [3:0] IDX_LAST       = 4'd8;
endpackage

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int N_SMP      = 100,
  parameter int SETTLE_CYC = 1387500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       smp_valid_i,
  input  logic       wr_ready_i,
  input  logic       div_done_i,
  output logic       wr_valid_o,
  output logic [3:0] wr_idx_o,
  output logic       acc_clr_o,
  output logic       acc_en_o,
  output logic       div_start_o,
  output logic [1:0] axis_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int SCW = $clog2(SETTLE_CYC + 1);
  localparam int NCW = $clog2(N_SMP + 1);

  cal_st_e        state_q;
  logic [3:0]     widx_q;
  logic [SCW-1:0] stl_q;
  logic [NCW-1:0] cnt_q;
  logic [1:0]     axis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      stl_q   <= '0;
      cnt_q   <= '0;
      axis_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CFG;
          widx_q  <= '0;
        end
        ST_CFG: if (wr_ready_i) begin
          if (widx_q == IDX_LAST_CLR) begin
            state_q <= ST_SETTLE;
            stl_q   <= '0;
          end else begin
            widx_q <= widx_q + 4'd1;
          end
        end
        ST_SETTLE: begin
          if (stl_q == SCW'(SETTLE_CYC - 1)) begin
            state_q <= ST_ACC;
            cnt_q   <= '0;
          end else begin
            stl_q <= stl_q + 1'b1;
          end
        end
        ST_ACC: if (smp_valid_i) begin
          if (cnt_q == NCW'(N_SMP - 1)) begin
            state_q <= ST_DGO;
            axis_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DGO: state_q <= ST_DWAIT;
        ST_DWAIT: if (div_done_i) begin
          if (axis_q == 2'd2) begin
            state_q <= ST_TRIM;
            widx_q  <= IDX_FIRST_TRIM;
          end else begin
            axis_q  <= axis_q + 2'd1;
            state_q <= ST_DGO;
          end
        end
        ST_TRIM: if (wr_ready_i) begin
          if (widx_q == IDX_LAST) state_q <= ST_DONE;
          else                    widx_q  <= widx_q + 4'd1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_valid_o  = (state_q == ST_CFG) || (state_q == ST_TRIM);
    acc_clr_o   = (state_q == ST_IDLE) && start_i;
    acc_en_o    = (state_q == ST_ACC) && smp_valid_i;
    div_start_o = (state_q == ST_DGO);
    busy_o      = (state_q != ST_IDLE);
    done_o      = (state_q == ST_DONE);
  end

  assign wr_idx_o = widx_q;
  assign axis_o   = axis_q;
endmodule

// File: rtl/cal_accum.sv
module cal_accum
  import cal_pkg::*;
#(
  parameter int SW = 16,
  parameter int AW = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [NAX-1:0][SW-1:0]  smp_i,
  output logic [NAX-1:0][AW-1:0]  sum_o
);
  for (genvar a = 0; a < NAX; a++) begin : g_ax
    logic [AW-1:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= acc_q + AW'($signed(smp_i[a]));
    end
    assign sum_o[a] = acc_q;
  end
endmodule

// File: rtl/cal_divsat.sv
module cal_divsat
  import cal_pkg::*;
#(
  parameter int AW    = 23,
  parameter int N_SMP = 100,
  parameter int GRAV  = 256,
  parameter int SCALE = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] sum_i,
  input  logic          grav_i,
  output logic          done_o,
  output logic [TW-1:0] trim_o,
  output logic          oor_o
);
  localparam int DW      = AW + 2;
  localparam int DIVISOR = SCALE * N_SMP;
  localparam int RW      = $clog2(DIVISOR) + 1;
  localparam int CW      = $clog2(DW + 1);
  localparam logic [DW-1:0] REF_SUM = DW'(GRAV * N_SMP);
  localparam logic [DW-1:0] HALF    = DW'(DIVISOR / 2);
  localparam logic [DW-1:0] POS_LIM = DW'(2 ** (TW - 1) - 1);
  localparam logic [DW-1:0] NEG_LIM = DW'(2 ** (TW - 1));

  logic [DW-1:0] sum_x, diff, mag, mag_r;
  logic [RW:0]   rem_sh, rem_sub;
  logic          fits;

  logic [DW-1:0] dvd_q, quo_q;
  logic [RW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q, run_q, done_q;

  always_comb begin
    sum_x   = DW'($signed(sum_i));
    diff    = (grav_i ? REF_SUM : '0) - sum_x;
    mag     = diff[DW-1] ? (~diff + 1'b1) : diff;
    mag_r   = mag + HALF;   // round half away from zero on the magnitude
    rem_sh  = {rem_q, dvd_q[DW-1]};
    rem_sub = rem_sh - (RW+1)'(DIVISOR);
    fits    = rem_sh >= (RW+1)'(DIVISOR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dvd_q <= mag_r;
        quo_q <= '0;
        rem_q <= '0;
        cnt_q <= CW'(DW);
        neg_q <= diff[DW-1];
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? rem_sub[RW-1:0] : rem_sh[RW-1:0];
        quo_q <= {quo_q[DW-2:0], fits};
        dvd_q <= {dvd_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    oor_o = 1'b0;
    if (!neg_q) begin
      if (quo_q > POS_LIM) begin
        trim_o = TW'(POS_LIM);
        oor_o  = 1'b1;
      end else begin
        trim_o = quo_q[TW-1:0];
      end
    end else begin
      if (quo_q > NEG_LIM) begin
        trim_o = TW'(NEG_LIM);
        oor_o  = 1'b1;
      end else begin
        trim_o = ~quo_q[TW-1:0] + 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/accel_offset_cal.sv
module accel_offset_cal
  import cal_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int N_SMP      = 100,
  parameter int SETTLE_CYC = 1387500,
  parameter int GRAV_LSB   = 256,
  parameter int OFS_SCALE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_x_i,
  input  logic [SMP_W-1:0] smp_y_i,
  input  logic [SMP_W-1:0] smp_z_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [7:0]       wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [TW-1:0]    trim_x_o,
  output logic [TW-1:0]    trim_y_o,
  output logic [TW-1:0]    trim_z_o,
  output logic [NAX-1:0]   oor_o
);
  localparam int AW = SMP_W + $clog2(N_SMP + 1);

  logic [3:0] wr_idx;
  logic       acc_clr, acc_en, div_start, div_done, div_oor;
  logic [1:0] axis;
  logic [TW-1:0] div_trim;
  logic [NAX-1:0][SMP_W-1:0] smp;
  logic [NAX-1:0][AW-1:0]    sums;
  logic [AW-1:0]             sum_sel;
  logic [NAX-1:0][TW-1:0]    trim_q;
  logic [NAX-1:0]            oor_q;

  assign smp = {smp_z_i, smp_y_i, smp_x_i};

  cal_seq #(.N_SMP(N_SMP), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i, .smp_valid_i, .wr_ready_i,
    .div_done_i  (div_done),
    .wr_valid_o,
    .wr_idx_o    (wr_idx),
    .acc_clr_o   (acc_clr),
    .acc_en_o    (acc_en),
    .div_start_o (div_start),
    .axis_o      (axis),
    .busy_o, .done_o
  );

  cal_accum #(.SW(SMP_W), .AW(AW)) u_acc (
    .clk_i, .rst_ni,
    .clr_i (acc_clr),
    .en_i  (acc_en),
    .smp_i (smp),
    .sum_o (sums)
  );

  always_comb begin
    case (axis)
      2'd0:    sum_sel = sums[0];
      2'd1:    sum_sel = sums[1];
      default: sum_sel = sums[2];
    endcase
  end

  cal_divsat #(.AW(AW), .N_SMP(N_SMP), .GRAV(GRAV_LSB), .SCALE(OFS_SCALE)) u_div (
    .clk_i, .rst_ni,
    .start_i (div_start),
    .sum_i   (sum_sel),
    .grav_i  (axis == 2'd2),
    .done_o  (div_done),
    .trim_o  (div_trim),
    .oor_o   (div_oor)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= '0;
      oor_q  <= '0;
    end else if (acc_clr) begin
      trim_q <= '0;
      oor_q  <= '0;
    end else if (div_done) begin
      case (axis)
        2'd0:    begin trim_q[0] <= div_trim; oor_q[0] <= div_oor; end
        2'd1:    begin trim_q[1] <= div_trim; oor_q[1] <= div_oor; end
        default: begin trim_q[2] <= div_trim; oor_q[2] <= div_oor; end
      endcase
    end
  end

  always_comb begin
    case (wr_idx)
      4'd0:    {wr_addr_o, wr_data_o} = {A_FMT,   V_FMT};
      4'd1:    {wr_addr_o, wr_data_o} = {A_PWR,   V_PWR};
      4'd2:    {wr_addr_o, wr_data_o} = {A_IEN,   V_IEN};
      4'd3:    {wr_addr_o, wr_data_o} = {A_OFS_X, 8'h00};
      4'd4:    {wr_addr_o, wr_data_o} = {A_OFS_Y, 8'h00};
      4'd5:    {wr_addr_o, wr_data_o} = {A_OFS_Z, 8'h00};
      4'd6:    {wr_addr_o, wr_data_o} = {A_OFS_X, trim_q[0]};
      4'd7:    {wr_addr_o, wr_data_o} = {A_OFS_Y, trim_q[1]};
      default: {wr_addr_o, wr_data_o} = {A_OFS_Z, trim_q[2]};
    endcase
  end

  assign trim_x_o = trim_q[0];
  assign trim_y_o = trim_q[1];
  assign trim_z_o = trim_q[2];
  assign oor_o    = oor_q;
endmodule

// File: rtl/accel_offset_cal_chk.sv
module accel_offset_cal_chk
  import cal_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_valid_o,
  input logic           wr_ready_i,
  input logic [7:0]     wr_addr_o,
  input logic [7:0]     wr_data_o,
  input logic           busy_o,
  input logic           done_o,
  input logic [TW-1:0]  trim_x_o,
  input logic [TW-1:0]  trim_y_o,
  input logic [TW-1:0]  trim_z_o,
  input logic [NAX-1:0] oor_o
);
  p_wr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_valid_o && !done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_done_after_z_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_valid_o && wr_ready_i && wr_addr_o == A_OFS_Z));

  p_busy_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  p_oor_rail_x_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && oor_o[0] |-> (trim_x_o == 8'h7F || trim_x_o == 8'h80));
  p_oor_rail_y_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && oor_o[1] |-> (trim_y_o == 8'h7F || trim_y_o == 8'h80));
  p_oor_rail_z_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && oor_o[2] |-> (trim_z_o == 8'h7F || trim_z_o == 8'h80));
endmodule

bind accel_offset_cal accel_offset_cal_chk u_chk (.*);

// File: tb/sim_accel_offset_cal.sv
module sim_accel_offset_cal;
  localparam int SETTLE = 40;
  localparam int N      = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, smp_v = 1'b0, wr_ready = 1'b0;
  logic [15:0] sx = '0, sy = '0, sz = '0;
  logic wr_valid, busy, done;
  logic [7:0] wr_addr, wr_data, tx, ty, tz;
  logic [2:0] oor;

  int tests = 0, fails = 0, wn = 0, dn = 0;
  logic [7:0] wa [0:511];
  logic [7:0] wd [0:511];

  always #4 clk = ~clk;

  accel_offset_cal #(.SETTLE_CYC(SETTLE), .N_SMP(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .smp_valid_i(smp_v),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .trim_x_o(tx), .trim_y_o(ty), .trim_z_o(tz), .oor_o(oor)
  );

  always @(negedge clk) wr_ready <= rst_n && (($urandom % 4) != 0);

  // monitor: 2 ns before each rising edge
  initial forever begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (wr_valid && wr_ready && wn < 512) begin
        wa[wn] = wr_addr; wd[wn] = wr_data; wn++;
      end
      if (done) dn++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_trim(input longint s, input longint gref, output bit o);
    longint d, m, q;
    d = gref * N - s;
    m = (d < 0) ? -d : d;
    q = (m + 2 * N) / (4 * N);
    o = 1'b0;
    if (d >= 0) begin
      if (q > 127) begin o = 1'b1; return 127; end
      return int'(q);
    end
    if (q > 128) begin o = 1'b1; return -128; end
    return -int'(q);
  endfunction

  function automatic int clip16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int jit(input int spr);
    if (spr == 0) return 0;
    return int'($urandom % (2 * spr + 1)) - spr;
  endfunction

  task automatic run_cal(input int bx, input int by, input int bz, input int spr, input bit poke);
    longint ssx = 0, ssy = 0, ssz = 0;
    int w0 = wn, d0 = dn, k = 0, x, y, z, ex, ey, ez;
    bit ox, oy, oz;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (wn < w0 + 6) @(negedge clk);
    // junk during settling must be ignored (R3)
    for (int i = 0; i < SETTLE - 2; i++) begin
      smp_v = 1'b1; sx = 16'h7000; sy = 16'h9000; sz = 16'h7000;
      start = poke && (i == 3);
      @(negedge clk);
    end
    start = 1'b0; smp_v = 1'b0;
    repeat (4) @(negedge clk);
    while (k < N) begin
      if (($urandom % 4) == 0) smp_v = 1'b0;
      else begin
        x = clip16(bx + jit(spr)); y = clip16(by + jit(spr)); z = clip16(bz + jit(spr));
        sx = 16'(x); sy = 16'(y); sz = 16'(z);
        ssx += x; ssy += y; ssz += z; smp_v = 1'b1; k++;
      end
      @(negedge clk);
    end
    // samples past the window must be ignored (R4)
    smp_v = 1'b1; sx = 16'h7FFF; sy = 16'h8000; sz = 16'h7FFF;
    repeat (3) @(negedge clk);
    smp_v = 1'b0;
    while (dn == d0) @(negedge clk);
    repeat (15) @(negedge clk);

    ex = exp_trim(ssx, 0, ox);
    ey = exp_trim(ssy, 0, oy);
    ez = exp_trim(ssz, 256, oz);
    chk(poke ? "R9" : "R1", "write count", wn - w0, 9);
    chk(poke ? "R9" : "R8", "done pulses", dn - d0, 1);
    chk("R8", "busy after done", int'(busy), 0);
    chk("R1", "cfg write 0", {wa[w0],   wd[w0]},   16'h310B);
    chk("R1", "cfg write 1", {wa[w0+1], wd[w0+1]}, 16'h2D08);
    chk("R1", "cfg write 2", {wa[w0+2], wd[w0+2]}, 16'h2E80);
    chk("R1", "clear X", {wa[w0+3], wd[w0+3]}, 16'h1E00);
    chk("R1", "clear Y", {wa[w0+4], wd[w0+4]}, 16'h1F00);
    chk("R1", "clear Z", {wa[w0+5], wd[w0+5]}, 16'h2000);
    chk("R7", "trim write X", {wa[w0+6], wd[w0+6]}, {8'h1E, 8'(ex)});
    chk("R7", "trim write Y", {wa[w0+7], wd[w0+7]}, {8'h1F, 8'(ey)});
    chk("R7", "trim write Z", {wa[w0+8], wd[w0+8]}, {8'h20, 8'(ez)});
    chk("R3 R4 R5", "trim X", int'($signed(tx)), ex);
    chk("R3 R4 R5", "trim Y", int'($signed(ty)), ey);
    chk("R3 R4 R5", "trim Z", int'($signed(tz)), ez);
    chk("R6", "oor flags", int'(oor), int'({oz, oy, ox}));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10", "busy at reset",  int'(busy), 0);
    chk("R10", "done at reset",  int'(done), 0);
    chk("R10", "wr_valid at reset", int'(wr_valid), 0);
    chk("R10", "trims at reset", int'({tx, ty, tz}), 0);
    chk("R10", "oor at reset", int'(oor), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cal(0, 0, 256, 0, 0);            // level: all zero
    run_cal(40, -24, 276, 0, 0);         // R5 plain values
    run_cal(6, -6, 258, 0, 0);           // R5 half-step ties
    run_cal(-508, -510, 768, 0, 0);      // R6 127 unflagged, 128 clipped, -128 unflagged
    run_cal(1000, -1000, -1744, 0, 0);   // R6 deep saturation
    run_cal(32767, -32768, 32767, 0, 0); // R6 extremes
    run_cal(10, 20, 300, 5, 1);          // R9 start while busy
    for (int r = 0; r < 6; r++)
      run_cal(int'($urandom % 1401) - 700, int'($urandom % 1401) - 700,
              256 + int'($urandom % 1401) - 700, int'($urandom % 61), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule